// File: doc/BRIEF.md
# Two-Master Peripheral Register Bus

This block is the fabric of a register bus. It joins two requesting masters to a set of memory-mapped peripheral register slaves. Master 0 is the core data port. Master 1 is a host-bridge port, and it has the higher priority. Each master holds a request with a byte address, an access size, a write flag and write data until it sees a one-cycle ready pulse. Read data and an error flag are valid during that pulse.

The fabric grants one master at a time. It decodes the slave from the upper address bits, using a base and a power-of-two size for each slave. Every transfer has two phases. In the address phase the selected slave is strobed. In the data phase the requesting master receives ready. Accesses that break the size and alignment rule, or that fall outside every slave window, still take the same two phases. They never reach a slave and complete with an error.

Top module: `regbus_fabric`

## Requirements
- R1: When both masters assert a new request while the bus is idle, master 1 (host bridge) is served first.
- R2: A request raised while the bus is idle receives ready two cycles after it is first seen. No request waits more than four cycles from the cycle it is first seen to its ready cycle.
- R3: A transfer holds the slave select for exactly one cycle. Ready goes to the owning master in the following cycle. Only one master sees ready in any cycle, and never while that master is not requesting. In reset, ready and all slave selects are low.
- R4: A transfer, once it is granted, is never pre-empted. A request that arrives during the address phase of another transfer is granted in that transfer's data phase, so its own address phase follows with no idle cycle.
- R5: The size field is encoded as 0 = byte, 1 = halfword, 2 = word, 3 = reserved. Byte and reserved sizes complete with err_o high.
- R6: A halfword access with address bit 0 set, or a word access with address bits [1:0] not zero, completes with err_o high.
- R7: Slave i is selected when the address, with its low SLV_SIZE_LOG2[i] bits cleared, equals the base of slave i. An address that hits no slave completes with err_o high.
- R8: An erroring access asserts no slave select and returns zero read data. It keeps the same two-cycle timing.
- R9: The byte enables are 4'b1111 for a word write. For a halfword write they are 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. Write data is passed through unchanged, and the master places a halfword in its lane.
- R10: A legal read returns, during ready, the full 32-bit word that the selected slave presents in the address phase, with err_o low.
- R11: In its ready cycle, the finishing master is not a candidate for arbitration. A waiting other master is therefore granted at once, so the core port cannot be starved by back-to-back host requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 2 | Request per master (bit 1 = host bridge) |
| addr_i | input | 2 x ADDR_W | Byte address per master |
| size_i | input | 2 x 2 | Access size per master |
| we_i | input | 2 | Write flag per master |
| wdata_i | input | 2 x 32 | Write data per master |
| ready_o | output | 2 | Completion pulse per master |
| rdata_o | output | 32 | Read data, valid with ready |
| err_o | output | 1 | Error flag, valid with ready |
| slv_sel_o | output | N_SLV | One-hot slave select, address phase |
| slv_addr_o | output | ADDR_W | Address to slaves |
| slv_we_o | output | 1 | Write strobe to slaves |
| slv_be_o | output | 4 | Byte enables to slaves |
| slv_wdata_o | output | 32 | Write data to slaves |
| slv_rdata_i | input | N_SLV x 32 | Read data from each slave |

## Verification
Some properties are checked by assertions on every cycle:
- ready is one-hot and goes only to a requesting master;
- a select is always followed by a legal ready, and an error pulse follows a cycle with no select and carries zero data;
- a granted transfer is never pre-empted;
- the host wins a simultaneous start, and the waiting master wins in the data phase;
- the byte-enable patterns are legal.

Other properties can only be shown by the bench's scenarios. These are:
- the exact request-to-ready latencies under contention;
- the written contents as they appear through later reads;
- which error cause applies to each illegal access;
- the lane chosen by each halfword write.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned N_MST  = 2;
  localparam logic        MST_CORE = 1'b0;
  localparam logic        MST_HOST = 1'b1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  function automatic logic size_legal(logic [1:0] sz, logic [1:0] lsb);
    case (sz)
      SZ_HALF: size_legal = ~lsb[0];
      SZ_WORD: size_legal = (lsb == 2'b00);
      default: size_legal = 1'b0;
    endcase
  endfunction

  function automatic logic [BE_W-1:0] lane_be(logic [1:0] sz, logic a1);
    if (sz == SZ_WORD) lane_be = '1;
    else if (a1)       lane_be = 4'b1100;
    else               lane_be = 4'b0011;
  endfunction
endpackage

// File: rtl/regbus_arb.sv
module regbus_arb
  import regbus_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] req_i,
  output phase_e           phase_o,
  output logic             owner_o
);
  phase_e           phase_q;
  logic             owner_q;
  logic [N_MST-1:0] excl;
  logic [N_MST-1:0] elig;
  logic             grant;
  logic             win;

  // the master completing in the data phase still holds req; drop it
  always_comb begin
    excl  = (phase_q == PH_DATA) ? (N_MST'(1) << owner_q) : '0;
    elig  = (phase_q == PH_ADDR) ? '0 : (req_i & ~excl);
    grant = |elig;
    win   = elig[MST_HOST] ? MST_HOST : MST_CORE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      owner_q <= MST_CORE;
    end else begin
      case (phase_q)
        PH_ADDR: phase_q <= PH_DATA;
        default: begin
          phase_q <= grant ? PH_ADDR : PH_IDLE;
          if (grant) owner_q <= win;
        end
      endcase
    end
  end

  assign phase_o = phase_q;
  assign owner_o = owner_q;

  p_host_wins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && req_i == 2'b11) |=> (phase_q == PH_ADDR && owner_q == MST_HOST));

  p_no_preempt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ADDR) |=> (phase_q == PH_DATA && $stable(owner_q)));

  p_other_next_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DATA && req_i[!owner_q]) |=> (phase_q == PH_ADDR && owner_q != $past(owner_q)));
endmodule

// File: rtl/regbus_decode.sv
module regbus_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned N_SLV  = 4,
  parameter logic [N_SLV*ADDR_W-1:0] SLV_BASE = '0,
  parameter logic [N_SLV*8-1:0]      SLV_SIZE_LOG2 = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_SLV-1:0]  hit_o
);
  for (genvar i = 0; i < N_SLV; i++) begin : g_win
    localparam int unsigned       SZ   = int'(SLV_SIZE_LOG2[i*8 +: 8]);
    localparam logic [ADDR_W-1:0] MASK = {ADDR_W{1'b1}} << SZ;
    localparam logic [ADDR_W-1:0] BASE = SLV_BASE[i*ADDR_W +: ADDR_W];
    assign hit_o[i] = ((addr_i & MASK) == (BASE & MASK));
  end
endmodule

// File: rtl/regbus_resp.sv
module regbus_resp
  import regbus_pkg::*;
#(
  parameter int unsigned N_SLV = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           addr_ph_i,
  input  logic                           owner_i,
  input  logic                           legal_i,
  input  logic [N_SLV-1:0]               hit_i,
  input  logic [N_SLV-1:0][DATA_W-1:0]   slv_rdata_i,
  output logic [N_MST-1:0]               ready_o,
  output logic [DATA_W-1:0]              rdata_o,
  output logic                           err_o
);
  logic [DATA_W-1:0] rmux;
  logic [N_MST-1:0]  ready_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;

  always_comb begin
    rmux = '0;
    for (int i = 0; i < N_SLV; i++)
      if (hit_i[i]) rmux = rmux | slv_rdata_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (addr_ph_i) begin
      ready_q <= N_MST'(1) << owner_i;
      rdata_q <= legal_i ? rmux : '0;
      err_q   <= ~legal_i;
    end else begin
      ready_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end
  end

  assign ready_o = ready_q;
  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  p_one_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ready_o));

  p_err_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ready_o && err_o) |-> (rdata_o == '0));
endmodule

// File: rtl/regbus_fabric.sv
module regbus_fabric
  import regbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned N_SLV  = 4,
  parameter logic [N_SLV*ADDR_W-1:0] SLV_BASE = {16'h1400, 16'h1200, 16'h1100, 16'h1000},
  parameter logic [N_SLV*8-1:0]      SLV_SIZE_LOG2 = {8'd8, 8'd8, 8'd8, 8'd8}
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [N_MST-1:0]                 req_i,
  input  logic [N_MST-1:0][ADDR_W-1:0]     addr_i,
  input  logic [N_MST-1:0][1:0]            size_i,
  input  logic [N_MST-1:0]                 we_i,
  input  logic [N_MST-1:0][DATA_W-1:0]     wdata_i,
  output logic [N_MST-1:0]                 ready_o,
  output logic [DATA_W-1:0]                rdata_o,
  output logic                             err_o,
  output logic [N_SLV-1:0]                 slv_sel_o,
  output logic [ADDR_W-1:0]                slv_addr_o,
  output logic                             slv_we_o,
  output logic [BE_W-1:0]                  slv_be_o,
  output logic [DATA_W-1:0]                slv_wdata_o,
  input  logic [N_SLV-1:0][DATA_W-1:0]     slv_rdata_i
);
  phase_e            phase;
  logic              owner;
  logic              addr_ph;
  logic [ADDR_W-1:0] m_addr;
  logic [1:0]        m_size;
  logic              m_we;
  logic [DATA_W-1:0] m_wdata;
  logic [N_SLV-1:0]  hit;
  logic              legal;

  regbus_arb u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .phase_o (phase),
    .owner_o (owner)
  );

  // owner is registered, so the request fields are muxed without a decision path
  assign addr_ph = (phase == PH_ADDR);
  assign m_addr  = addr_i[owner];
  assign m_size  = size_i[owner];
  assign m_we    = we_i[owner];
  assign m_wdata = wdata_i[owner];

  regbus_decode #(
    .ADDR_W        (ADDR_W),
    .N_SLV         (N_SLV),
    .SLV_BASE      (SLV_BASE),
    .SLV_SIZE_LOG2 (SLV_SIZE_LOG2)
  ) u_dec (
    .addr_i (m_addr),
    .hit_o  (hit)
  );

  assign legal = size_legal(m_size, m_addr[1:0]) && (|hit);

  assign slv_sel_o   = (addr_ph && legal) ? hit : '0;
  assign slv_addr_o  = m_addr;
  assign slv_we_o    = addr_ph && legal && m_we;
  assign slv_be_o    = lane_be(m_size, m_addr[1]);
  assign slv_wdata_o = m_wdata;

  regbus_resp #(.N_SLV(N_SLV)) u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_ph_i   (addr_ph),
    .owner_i     (owner),
    .legal_i     (legal),
    .hit_i       (hit),
    .slv_rdata_i (slv_rdata_i),
    .ready_o     (ready_o),
    .rdata_o     (rdata_o),
    .err_o       (err_o)
  );

  p_sel_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slv_sel_o));

  p_ready_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o & ~req_i) == '0);

  p_sel_then_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|slv_sel_o) |=> (|ready_o && !err_o));

  p_err_nosel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ready_o && err_o) |-> ($past(slv_sel_o) == '0));

  p_be_lane_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slv_we_o |-> (slv_be_o == 4'b1111 || slv_be_o == 4'b0011 || slv_be_o == 4'b1100));
endmodule

// File: tb/regbus_fabric_tb.sv
`timescale 1ns/1ps
module regbus_fabric_tb_top;
  localparam int NS = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        req = '0;
  logic [1:0][15:0]  addr = '0;
  logic [1:0][1:0]   size = '0;
  logic [1:0]        we = '0;
  logic [1:0][31:0]  wdata = '0;
  logic [1:0]        ready;
  logic [31:0]       rdata;
  logic              err;
  logic [NS-1:0]     slv_sel;
  logic [15:0]       slv_addr;
  logic              slv_we;
  logic [3:0]        slv_be;
  logic [31:0]       slv_wdata;
  logic [NS-1:0][31:0] slv_rdata;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  logic [31:0] smem [NS][64];
  logic [31:0] rmem [NS][64];

  always #10 clk = ~clk;

  regbus_fabric dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .size_i(size),
    .we_i(we), .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .err_o(err),
    .slv_sel_o(slv_sel), .slv_addr_o(slv_addr), .slv_we_o(slv_we),
    .slv_be_o(slv_be), .slv_wdata_o(slv_wdata), .slv_rdata_i(slv_rdata)
  );

  // slave register files
  always_comb
    for (int s = 0; s < NS; s++) slv_rdata[s] = smem[s][slv_addr[7:2]];

  always @(posedge clk)
    for (int s = 0; s < NS; s++)
      if (slv_sel[s] && slv_we)
        for (int b = 0; b < 4; b++)
          if (slv_be[b]) smem[s][slv_addr[7:2]][b*8 +: 8] <= slv_wdata[b*8 +: 8];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // behavioural timing model: phase 0 idle, 1 address, 2 data
  int ph = 0;
  int own = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0;
    end else if (ph == 1) begin
      ph = 2;
    end else begin
      logic [1:0] cand;
      cand = req;
      if (ph == 2) cand[own] = 1'b0;
      if (cand != 0) begin
        own = cand[1] ? 1 : 0;
        ph = 1;
      end else ph = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [1:0] er;
      er = (ph == 2) ? (2'b01 << own) : 2'b00;
      chk(ready == er, "R3", "ready per cycle", {30'd0, ready}, {30'd0, er});
    end else begin
      chk(ready == 0 && slv_sel == 0, "R3", "reset outputs",
          {26'd0, slv_sel, ready}, 32'd0);
    end
  end

  function automatic int slave_of(logic [15:0] a);
    case (a[15:8])
      8'h10: return 0;
      8'h11: return 1;
      8'h12: return 2;
      8'h14: return 3;
      default: return -1;
    endcase
  endfunction

  // call at posedge + 1; returns at posedge + 1 after ready
  task automatic acc(input int m, input logic [15:0] a, input logic [1:0] sz,
                     input logic w, input logic [31:0] wd, output int lat);
    logic [NS-1:0] psel;
    logic [3:0] pbe;
    logic [31:0] pwd;
    logic [3:0] ebe;
    int s;
    bit szok, alok, lg;
    string tag;
    req[m] = 1'b1; addr[m] = a; size[m] = sz; we[m] = w; wdata[m] = wd;
    lat = 0;
    psel = '0; pbe = '0; pwd = '0;
    forever begin
      @(negedge clk);
      lat++;
      if (ready[m]) break;
      psel = slv_sel; pbe = slv_be; pwd = slv_wdata;
    end
    s = slave_of(a);
    szok = (sz == 2'd1 || sz == 2'd2);
    alok = (sz == 2'd1) ? !a[0] : (a[1:0] == 2'b00);
    lg = szok && alok && (s >= 0);
    tag = !szok ? "R5" : (!alok ? "R6" : (s < 0 ? "R7" : "R10"));
    ebe = (sz == 2'd2) ? 4'hf : (a[1] ? 4'hc : 4'h3);
    chk(err == !lg, tag, "err flag", {31'd0, err}, {31'd0, !lg});
    if (!lg) begin
      chk(rdata == 0, "R8", "error read data", rdata, 32'd0);
      chk(psel == 0, "R8", "no select on error", {28'd0, psel}, 32'd0);
    end else begin
      chk(psel == (NS'(1) << s), "R7", "slave select", {28'd0, psel}, 32'd1 << s);
      if (w) begin
        chk(pbe == ebe, "R9", "byte enables", {28'd0, pbe}, {28'd0, ebe});
        chk(pwd == wd, "R9", "write data", pwd, wd);
        for (int b = 0; b < 4; b++)
          if (ebe[b]) rmem[s][a[7:2]][b*8 +: 8] = wd[b*8 +: 8];
      end else begin
        chk(rdata == rmem[s][a[7:2]], "R10", "read data", rdata, rmem[s][a[7:2]]);
      end
    end
    @(posedge clk);
    #1;
    req[m] = 1'b0;
  endtask

  task automatic lat_chk(input string rq, input int act, input int exp);
    chk(act == exp, rq, "latency", act, exp);
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: actual %0d expected < 100000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : main
    int l0, l1, l2;
    logic [31:0] junk;
    junk = 0;
    for (int s = 0; s < NS; s++)
      for (int i = 0; i < 64; i++) begin
        smem[s][i] = 32'h0;
        rmem[s][i] = 32'h0;
      end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R10 R2: core word write and read-back, idle bus
    acc(0, 16'h1004, 2'd2, 1'b1, 32'hdeadbeef, l0); lat_chk("R2", l0, 3);
    acc(0, 16'h1004, 2'd2, 1'b0, 32'h0, l0);        lat_chk("R2", l0, 3);
    // R9: host halfword writes to both lanes, then word read
    acc(1, 16'h1108, 2'd1, 1'b1, 32'h0000a5a5, l0);
    acc(1, 16'h110a, 2'd1, 1'b1, 32'h3c3c0000, l0);
    acc(0, 16'h1108, 2'd2, 1'b0, 32'h0, l0);
    acc(1, 16'h1402, 2'd1, 1'b1, 32'h77770000, l0);
    acc(1, 16'h1400, 2'd2, 1'b0, 32'h0, l0);
    // R5 R8: byte and reserved sizes
    acc(0, 16'h1004, 2'd0, 1'b1, 32'h11111111, l0); lat_chk("R8", l0, 3);
    acc(1, 16'h1004, 2'd3, 1'b0, 32'h0, l0);
    acc(0, 16'h1004, 2'd2, 1'b0, 32'h0, l0);
    // R6: misaligned
    acc(0, 16'h1201, 2'd1, 1'b1, 32'h12345678, l0);
    acc(1, 16'h1202, 2'd2, 1'b1, 32'h12345678, l0);
    // R7: unmapped hole
    acc(0, 16'h1300, 2'd2, 1'b1, 32'hcafef00d, l0);
    acc(1, 16'h1500, 2'd2, 1'b0, 32'h0, l0);

    // R1: simultaneous start, host first
    fork
      acc(0, 16'h1010, 2'd2, 1'b1, 32'h00000001, l0);
      acc(1, 16'h1010, 2'd2, 1'b1, 32'h00000002, l1);
    join
    lat_chk("R1", l1, 3);
    lat_chk("R1", l0, 5);
    acc(0, 16'h1010, 2'd2, 1'b0, 32'h0, l0);

    // R4: host arrives during core address phase
    fork
      acc(0, 16'h1020, 2'd2, 1'b1, 32'haaaa0001, l0);
      begin
        @(posedge clk); #1;
        acc(1, 16'h1020, 2'd2, 1'b0, 32'h0, l1);
      end
    join
    lat_chk("R4", l0, 3);
    lat_chk("R4", l1, 4);

    // R11: host back-to-back, core waiting
    fork
      acc(0, 16'h1030, 2'd2, 1'b1, 32'h0c0c0c0c, l0);
      begin
        acc(1, 16'h1034, 2'd2, 1'b1, 32'h1b1b1b1b, l1);
        acc(1, 16'h1038, 2'd2, 1'b1, 32'h2b2b2b2b, l2);
      end
    join
    lat_chk("R11", l0, 5);
    lat_chk("R11", l1, 3);
    lat_chk("R11", l2, 4);

    // R2: mixed random traffic from both masters
    fork
      for (int m = 0; m < 2; m++) begin
        fork
          automatic int mm = m;
          begin
            for (int k = 0; k < 150; k++) begin
              logic [15:0] ra;
              logic [1:0] rs;
              int lt;
              ra = {8'h10 + 8'($urandom_range(0, 5)), 8'($urandom)};
              rs = 2'($urandom_range(0, 9) < 7 ? ($urandom_range(0, 1) ? 2 : 1) : $urandom_range(0, 3));
              if ($urandom_range(0, 3) != 0) ra[1:0] = (rs == 2'd2) ? 2'b00 : {ra[1], 1'b0};
              acc(mm, ra, rs, 1'($urandom), $urandom, lt);
              chk(lt <= 5, "R2", "bounded wait", lt, 5);
              if ($urandom_range(0, 2) == 0) begin
                repeat ($urandom_range(1, 3)) @(posedge clk);
                #1;
              end
            end
          end
        join_none
      end
      wait fork;
    join

    if (junk != 0) $display("unused");
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule